// File: doc/BRIEF.md
# Rotate-Right Execution Unit

This unit sits beside the shift unit in the integer pipe of a 64-bit core. It looks at every instruction word that enters the execute stage and recognizes the rotate encodings. These encodings reuse the shift opcode space: the major opcode is zero, and a field that an ordinary shift leaves at zero carries the marker value 1. For the immediate forms that field is the rs field. For the register-amount forms it is the sa field.

For a recognized rotate, the unit rotates the RT operand right. The amount comes from the immediate shift field, from the low bits of the RS operand, or from the immediate plus 32. The unit works in word (32-bit) or doubleword (64-bit) width. It raises a combinational match flag in the same cycle, so that the neighbouring shift unit can stand down. The rotated value and its write enable leave one clock edge later.

There is no state machine. A decoded operation kind is classified in a `unique case` and drives the amount select and the width select. Two generated barrel rotators, one per width, feed a single result register.

Top module: `rot_exec_unit`

## Requirements
- R1: Word immediate rotate: instr[31:26]=0, rs field instr[25:21]=1, funct instr[5:0]=6'h02. The low 32 bits of RT are rotated right by sa instr[10:6].
- R2: Word variable rotate: instr[31:26]=0, sa field=1, funct=6'h06. The amount is rs_val[4:0], and rs_val[63:5] has no effect on the result.
- R3: Doubleword immediate rotate: instr[31:26]=0, rs field=1, funct=6'h3A. The 64-bit RT is rotated right by sa (0..31).
- R4: Doubleword high immediate rotate: instr[31:26]=0, rs field=1, funct=6'h3E. The 64-bit RT is rotated right by sa+32 (32..63).
- R5: Doubleword variable rotate: instr[31:26]=0, sa field=1, funct=6'h16. The amount is rs_val[5:0], and rs_val[63:6] has no effect.
- R6: A word result is sign-extended from its bit 31 into bits 63:32. rt_val[63:32] has no effect on a word result.
- R7: An amount of zero returns RT unchanged in doubleword mode, and returns RT[31:0] sign-extended in word mode.
- R8: out_match is high only when the major opcode is zero, the marker field equals 1 and the funct is one of the five codes above. A marker of 0 (plain shift) or any value above 1 keeps it low.
- R9: out_match is combinational from instr. out_wen and out_data show the instruction present at the previous rising clock edge, so the latency is one cycle.
- R10: While rst_n is low, out_wen and out_data are zero.
- R11: An edge with no match drives out_wen low and leaves out_data holding its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 32 | Instruction word in execute |
| rt_val | input | 64 | RT operand, the value rotated |
| rs_val | input | 64 | RS operand, source of the variable amount |
| out_data | output | 64 | Registered rotate result |
| out_wen | output | 1 | Registered destination write enable |
| out_match | output | 1 | Combinational rotate-recognized flag |

## Verification
The hardest case to reach is a register-amount rotate whose RS operand carries junk above the amount bits. The result must then depend only on bits 4:0 (word) or 5:0 (doubleword). A near-miss encoding, with the right funct but a marker of 0 or 2..31, must also leave the result register untouched.

Random stimulus produces such words on purpose. Every register-amount form draws a full 64-bit RS value. One stimulus class reuses a rotate funct with a random non-unit marker. Directed cases cover amounts 0, 31, 32 and 63, and an RT whose upper half disagrees with the sign of bit 31.

// File: rtl/rot_pkg.sv
package rot_pkg;

    typedef enum logic [2:0] {
        ROP_NONE,
        ROP_W_IMM,
        ROP_W_VAR,
        ROP_D_IMM,
        ROP_D_IMM_HI,
        ROP_D_VAR
    } rot_op_e;

    localparam logic [5:0] FN_W_IMM    = 6'h02;
    localparam logic [5:0] FN_W_VAR    = 6'h06;
    localparam logic [5:0] FN_D_IMM    = 6'h3A;
    localparam logic [5:0] FN_D_IMM_HI = 6'h3E;
    localparam logic [5:0] FN_D_VAR    = 6'h16;
    localparam logic [4:0] ROT_MARK    = 5'd1;
    localparam logic [5:0] OPC_SPECIAL = 6'd0;

    typedef struct packed {
        rot_op_e op;
        logic    word;
        logic    hit;
    } rot_ctl_t;

endpackage

// File: rtl/rot_decode.sv
module rot_decode
    import rot_pkg::*;
#(
    parameter int SHW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [31:0]    instr,
    input  logic [SHW-1:0] rs_amt,
    output rot_ctl_t       ctl,
    output logic [SHW-1:0] amt
);
    localparam logic [SHW-1:0] HI_OFS = SHW'(1) << (SHW - 1);

    logic [5:0] opc_f;
    logic [4:0] rs_f;
    logic [4:0] sa_f;
    logic [5:0] fn_f;
    logic       imm_mark;
    logic       var_mark;
    rot_op_e    op_c;
    logic       unused_fields;

    assign opc_f         = instr[31:26];
    assign rs_f          = instr[25:21];
    assign sa_f          = instr[10:6];
    assign fn_f          = instr[5:0];
    assign unused_fields = ^instr[20:11];

    assign imm_mark = (opc_f == OPC_SPECIAL) && (rs_f == ROT_MARK);
    assign var_mark = (opc_f == OPC_SPECIAL) && (sa_f == ROT_MARK);

    always_comb begin
        op_c = ROP_NONE;
        if (imm_mark && fn_f == FN_W_IMM)    op_c = ROP_W_IMM;
        if (var_mark && fn_f == FN_W_VAR)    op_c = ROP_W_VAR;
        if (imm_mark && fn_f == FN_D_IMM)    op_c = ROP_D_IMM;
        if (imm_mark && fn_f == FN_D_IMM_HI) op_c = ROP_D_IMM_HI;
        if (var_mark && fn_f == FN_D_VAR)    op_c = ROP_D_VAR;
    end

    always_comb begin
        ctl.op   = op_c;
        ctl.hit  = 1'b1;
        ctl.word = 1'b0;
        amt      = '0;
        unique case (op_c)
            ROP_W_IMM: begin
                ctl.word = 1'b1;
                amt      = SHW'(sa_f);
            end
            ROP_W_VAR: begin
                ctl.word = 1'b1;
                amt      = SHW'(rs_amt[SHW-2:0]);
            end
            ROP_D_IMM:    amt = SHW'(sa_f);
            ROP_D_IMM_HI: amt = SHW'(sa_f) | HI_OFS;
            ROP_D_VAR:    amt = rs_amt;
            default:      ctl.hit = 1'b0;
        endcase
    end

    // R8
    hit_needs_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.hit |-> (instr[31:26] == 6'd0));

    // R4
    hi_form_amount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.op == ROP_D_IMM_HI) |-> amt[SHW-1]);

endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
    parameter int W  = 64,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [0:AW];

    assign stage[0] = din;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stage[k+1] = amt[k] ? {stage[k][SH-1:0], stage[k][W-1:SH]}
                                   : stage[k];
    end

    assign dout = stage[AW];

endmodule

// File: rtl/rot_exec_unit.sv
module rot_exec_unit
    import rot_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rt_val,
    input  logic [XLEN-1:0] rs_val,
    output logic [XLEN-1:0] out_data,
    output logic            out_wen,
    output logic            out_match
);
    localparam int SHW  = $clog2(XLEN);
    localparam int HALF = XLEN / 2;
    localparam int HSHW = SHW - 1;

    rot_ctl_t        ctl;
    logic [SHW-1:0]  amt;
    logic [XLEN-1:0] rot_d;
    logic [HALF-1:0] rot_w;
    logic [XLEN-1:0] result_c;
    logic [XLEN-1:0] data_q;
    logic            wen_q;
    logic            unused_rs;

    assign unused_rs = ^rs_val[XLEN-1:SHW];

    rot_decode #(.SHW(SHW)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .instr  (instr),
        .rs_amt (rs_val[SHW-1:0]),
        .ctl    (ctl),
        .amt    (amt)
    );

    rot_barrel #(.W(XLEN), .AW(SHW)) u_rot_d (
        .din  (rt_val),
        .amt  (amt),
        .dout (rot_d)
    );

    rot_barrel #(.W(HALF), .AW(HSHW)) u_rot_w (
        .din  (rt_val[HALF-1:0]),
        .amt  (amt[HSHW-1:0]),
        .dout (rot_w)
    );

    assign result_c = ctl.word ? {{HALF{rot_w[HALF-1]}}, rot_w} : rot_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            wen_q  <= 1'b0;
        end else begin
            wen_q <= ctl.hit;
            if (ctl.hit) data_q <= result_c;
        end
    end

    assign out_data  = data_q;
    assign out_wen   = wen_q;
    assign out_match = ctl.hit;

    // R9
    wen_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_match |=> out_wen);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_match |=> (!out_wen && $stable(out_data)));

    // R6
    word_sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_match && ctl.word) |=>
            (out_data[XLEN-1:HALF] == {HALF{out_data[HALF-1]}}) &&
            ($countones(out_data[HALF-1:0]) == $countones($past(rt_val[HALF-1:0]))));

    // R3
    dbl_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_match && !ctl.word) |=>
            ($countones(out_data) == $countones($past(rt_val))));

    // R7
    zero_amt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_match && !ctl.word && amt == '0) |=> (out_data == $past(rt_val)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (!out_wen && out_data == '0));

endmodule

// File: tb/rot_exec_unit_bench.sv
module rot_exec_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rt_val = '0;
    logic [63:0] rs_val = '0;
    logic [63:0] out_data;
    logic        out_wen;
    logic        out_match;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_data = '0;

    always #5 clk = ~clk;

    rot_exec_unit u_rot_exec_unit (
        .clk(clk), .rst_n(rst_n), .instr(instr), .rt_val(rt_val),
        .rs_val(rs_val), .out_data(out_data), .out_wen(out_wen),
        .out_match(out_match)
    );

    function automatic logic [31:0] mk(input logic [4:0] rsf, input logic [4:0] rtf,
        input logic [4:0] rdf, input logic [4:0] saf, input logic [5:0] fn);
        return {6'd0, rsf, rtf, rdf, saf, fn};
    endfunction

    // returns {match, data}
    function automatic logic [64:0] ref_model(input logic [31:0] iw,
        input logic [63:0] rt, input logic [63:0] rs);
        logic [4:0] rsf = iw[25:21];
        logic [4:0] saf = iw[10:6];
        logic [5:0] fn  = iw[5:0];
        logic       hit = 1'b0;
        logic       wd  = 1'b0;
        int         n   = 0;
        logic [127:0] dd;
        logic [63:0]  ww;
        if (iw[31:26] == 6'd0) begin
            if (rsf == 5'd1 && fn == 6'h02) begin hit = 1; wd = 1; n = saf; end
            if (saf == 5'd1 && fn == 6'h06) begin hit = 1; wd = 1; n = rs[4:0]; end
            if (rsf == 5'd1 && fn == 6'h3A) begin hit = 1; n = saf; end
            if (rsf == 5'd1 && fn == 6'h3E) begin hit = 1; n = saf + 32; end
            if (saf == 5'd1 && fn == 6'h16) begin hit = 1; n = rs[5:0]; end
        end
        if (!hit) return {1'b0, 64'd0};
        if (wd) begin
            ww = {rt[31:0], rt[31:0]} >> n;
            return {1'b1, {32{ww[31]}}, ww[31:0]};
        end
        dd = {rt, rt} >> n;
        return {1'b1, dd[63:0]};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic apply(input string tag, input logic [31:0] iw,
        input logic [63:0] rt, input logic [63:0] rs);
        logic [64:0] r;
        instr = iw; rt_val = rt; rs_val = rs;
        r = ref_model(iw, rt, rs);
        #1;
        check({tag, " match R8"}, {63'd0, out_match}, {63'd0, r[64]});
        if (r[64]) exp_data = r[63:0];
        @(posedge clk);
        @(negedge clk);
        check({tag, " wen R9"}, {63'd0, out_wen}, {63'd0, r[64]});
        check({tag, " data"}, out_data, exp_data);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        check("R10 reset wen", {63'd0, out_wen}, 64'd0);
        check("R10 reset data", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        apply("R1 word imm", mk(1, 3, 4, 5'd1, 6'h02), 64'h12345678_80000001, 0);
        apply("R1 word imm 31", mk(1, 3, 4, 5'd31, 6'h02), 64'h0_00000001, 0);
        apply("R6 word upper ignored", mk(1, 3, 4, 5'd4, 6'h02), 64'hFFFFFFFF_00000070, 0);
        apply("R2 word var junk", mk(7, 3, 4, 5'd1, 6'h06), 64'h0_F0000000, 64'hFFFF_FFFF_FFFF_FFE3);
        apply("R3 dbl imm", mk(1, 3, 4, 5'd8, 6'h3A), 64'h01234567_89ABCDEF, 0);
        apply("R4 dbl hi 32", mk(1, 3, 4, 5'd0, 6'h3E), 64'h01234567_89ABCDEF, 0);
        apply("R4 dbl hi 63", mk(1, 3, 4, 5'd31, 6'h3E), 64'h80000000_00000001, 0);
        apply("R5 dbl var junk", mk(7, 3, 4, 5'd1, 6'h16), 64'h00000000_0000FFFF, 64'hABCD_0000_0000_00C4);
        apply("R7 dbl zero", mk(1, 3, 4, 5'd0, 6'h3A), 64'hDEADBEEF_CAFEF00D, 0);
        apply("R7 word zero", mk(1, 3, 4, 5'd0, 6'h02), 64'h0000FFFF_8000F00D, 0);
        apply("R7 var zero", mk(2, 3, 4, 5'd1, 6'h16), 64'h5555AAAA_1234_5678, 64'hFFFF_FFFF_FFFF_FFC0);
        apply("R8 R11 plain shift", mk(0, 3, 4, 5'd3, 6'h02), 64'h1, 0);
        apply("R8 R11 marker two", mk(2, 3, 4, 5'd3, 6'h3A), 64'h1, 0);
        apply("R8 R11 var marker two", mk(2, 3, 4, 5'd2, 6'h06), 64'h1, 5);
        apply("R8 R11 opcode set", {6'd1, 5'd1, 5'd3, 5'd4, 5'd3, 6'h02}, 64'h1, 0);

        for (int i = 0; i < 3000; i++) begin
            int kind;
            logic [31:0] iw;
            logic [63:0] rt, rs;
            logic [4:0] a, b, c, d;
            string tag;
            kind = $urandom_range(0, 6);
            a = 5'($urandom); b = 5'($urandom); c = 5'($urandom); d = 5'($urandom);
            rt = {$urandom, $urandom};
            rs = {$urandom, $urandom};
            case (kind)
                0: begin iw = mk(1, b, c, d, 6'h02); tag = "R1 rnd"; end
                1: begin iw = mk(a, b, c, 1, 6'h06); tag = "R2 rnd"; end
                2: begin iw = mk(1, b, c, d, 6'h3A); tag = "R3 rnd"; end
                3: begin iw = mk(1, b, c, d, 6'h3E); tag = "R4 rnd"; end
                4: begin iw = mk(a, b, c, 1, 6'h16); tag = "R5 rnd"; end
                5: begin
                    iw = mk((a == 5'd1) ? 5'd3 : a, b, c, (d == 5'd1) ? 5'd0 : d,
                            ($urandom_range(0, 1) == 0) ? 6'h3E : 6'h06);
                    tag = "R8 rnd near miss";
                end
                default: begin iw = $urandom; tag = "R11 rnd any"; end
            endcase
            apply(tag, iw, rt, rs);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule